// File: doc/BRIEF.md
# Converter Power-Mode Sequencer

This block sits in the digital core of a dual-channel converter and decides, from two slow level inputs, how much of the analog side is powered. A power-down request and an enable request are each brought through a two-flop synchronizer and then decoded by a four-state machine: `ST_SHUTDOWN` (reference, control amplifier and current array all off), `ST_STANDBY` (reference and amplifier on, current array off), `ST_SETTLE` (everything on, outputs not yet valid) and `ST_ACTIVE` (everything on, outputs valid). A power-down request wins over the enable.

The transitions are: `SHUTDOWN→STANDBY` when power-down drops with enable low; `SHUTDOWN→SETTLE` or `STANDBY→SETTLE` when power-down is low and enable is high; `SETTLE→ACTIVE` when the settle counter expires; `SETTLE→STANDBY` or `ACTIVE→STANDBY` when enable drops; any state `→SHUTDOWN` when power-down is high. The settle interval is `CLK_HZ/1000 * SETTLE_US / 1000` clock cycles (50 µs by default) and restarts from zero each time `ST_SETTLE` is entered. Reset puts the block in `ST_SHUTDOWN`.

While the outputs are not valid, an output-park control is raised: either a high-impedance request or a drive-to-ground request, chosen by the build parameter `OUT_GND`. The two channel codes are held in registers that accept new values only while the block is active, so after any sleep the converter returns to the codes it had before.

Top module: `dac_pwr_seq`

## Requirements
- R1: With power-down low and enable low (synchronized), the block is in standby: `ref_en`=1, `amp_en`=1, `arr_en`=0, `ready`=0.
- R2: With power-down low and enable high, once settling completes: `ref_en`, `amp_en`, `arr_en` and `ready` are all 1.
- R3: With power-down high, whatever the enable, `ref_en`, `amp_en` and `arr_en` are all 0 and `ready` is 0.
- R4: Whenever `ready` is 0, exactly one park bit is 1: `out_gnd` if `OUT_GND`=1, otherwise `out_hiz`; whenever `ready` is 1 both park bits are 0.
- R5: On entering the settle state `arr_en` rises with `ready` low; `ready` rises after exactly `SETTLE_CYC` cycles with `arr_en` high and `ready` low.
- R6: `code_ld` copies `code_a`/`code_b` into `dout_a`/`dout_b` on the next rising edge only when `ready` is 1; otherwise the held codes do not change, so wake-up restores the pre-sleep codes.
- R7: If enable drops or power-down rises during settling, the block leaves the settle state at once; a later wake restarts the full `SETTLE_CYC` count.
- R8: A change on `pd_req` or `en_req` reaches the enables on the third rising clock edge after it is applied (two synchronizer stages plus the state register).
- R9: During reset the block is in shutdown: all enables 0, `ready` 0, park bit per R4 set, `dout_a`=`dout_b`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pd_req | input | 1 | Power-down request level (asynchronous) |
| en_req | input | 1 | Enable request level (asynchronous) |
| code_a | input | CODE_W | New code for channel A |
| code_b | input | CODE_W | New code for channel B |
| code_ld | input | 1 | Load strobe for both channel codes |
| ref_en | output | 1 | Reference enable |
| amp_en | output | 1 | Control amplifier enable |
| arr_en | output | 1 | Current array enable |
| out_hiz | output | 1 | Request high-impedance outputs |
| out_gnd | output | 1 | Request outputs forced to ground |
| ready | output | 1 | Outputs valid |
| dout_a | output | CODE_W | Held code for channel A |
| dout_b | output | CODE_W | Held code for channel B |

## Verification
The checker watches every cycle that a synchronized power-down request turns off all three enables on the next edge, that synchronized standby inputs give the standby enable pattern, that the park bits are one-hot exactly while outputs are invalid, that held codes never move while `ready` is low, and that every rise of `ready` follows exactly the configured number of settle cycles. Only the bench scenarios can show the three-edge input latency from the raw pins, the restart of the count after an aborted wake, the reset values, and that codes written before a sleep come back unchanged after wake-up.

// File: rtl/dac_pwr_pkg.sv
package dac_pwr_pkg;

    typedef enum logic [1:0] {
        ST_SHUTDOWN = 2'd0,
        ST_STANDBY  = 2'd1,
        ST_SETTLE   = 2'd2,
        ST_ACTIVE   = 2'd3
    } pwr_state_t;

    // settle length in cycles, never below one
    function automatic int unsigned settle_cycles(input longint unsigned clk_hz,
                                                  input int unsigned settle_us);
        longint unsigned c;
        c = ((clk_hz / 1000) * settle_us) / 1000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/dac_pwr_sync.sv
module dac_pwr_sync #(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage1[g] <= RST_VAL[g];
                    stage2[g] <= RST_VAL[g];
                end else begin
                    stage1[g] <= d_async[g];
                    stage2[g] <= stage1[g];
                end
            end
        end
    endgenerate

    assign q_sync = stage2;
endmodule

// File: rtl/dac_pwr_settle.sv
module dac_pwr_settle #(
    parameter int unsigned CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int unsigned CW   = (CYC < 2) ? 1 : $clog2(CYC);
    localparam logic [CW-1:0] LAST = CW'(CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign done = run && (cnt == LAST);
endmodule

// File: rtl/dac_pwr_hold.sv
module dac_pwr_hold #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr) begin
            q <= d;
        end
    end
endmodule

// File: rtl/dac_pwr_seq.sv
module dac_pwr_seq
    import dac_pwr_pkg::*;
#(
    parameter longint unsigned CLK_HZ    = 100_000_000,
    parameter int unsigned     SETTLE_US = 50,
    parameter bit              OUT_GND   = 1'b0,
    parameter int              CODE_W    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_req,
    input  logic              en_req,
    input  logic [CODE_W-1:0] code_a,
    input  logic [CODE_W-1:0] code_b,
    input  logic              code_ld,
    output logic              ref_en,
    output logic              amp_en,
    output logic              arr_en,
    output logic              out_hiz,
    output logic              out_gnd,
    output logic              ready,
    output logic [CODE_W-1:0] dout_a,
    output logic [CODE_W-1:0] dout_b
);
    localparam int unsigned SETTLE_CYC = settle_cycles(CLK_HZ, SETTLE_US);
    localparam int          NCH        = 2;

    pwr_state_t state_q, state_d;
    logic       pd_s, en_s;
    logic [1:0] req_sync;
    logic       settle_done;
    logic       hold_wr;

    // pd resets high so the synchronized view agrees with shutdown
    dac_pwr_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async({pd_req, en_req}),
        .q_sync (req_sync)
    );
    assign pd_s = req_sync[1];
    assign en_s = req_sync[0];

    dac_pwr_settle #(.CYC(SETTLE_CYC)) u_settle (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state_q == ST_SETTLE),
        .done (settle_done)
    );

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SHUTDOWN: begin
                if (!pd_s) state_d = en_s ? ST_SETTLE : ST_STANDBY;
            end
            ST_STANDBY: begin
                if (pd_s)      state_d = ST_SHUTDOWN;
                else if (en_s) state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (pd_s)             state_d = ST_SHUTDOWN;
                else if (!en_s)       state_d = ST_STANDBY;
                else if (settle_done) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (pd_s)        state_d = ST_SHUTDOWN;
                else if (!en_s)  state_d = ST_STANDBY;
            end
            default: state_d = ST_SHUTDOWN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SHUTDOWN;
        else        state_q <= state_d;
    end

    // output decode
    always_comb begin
        ref_en = 1'b0;
        amp_en = 1'b0;
        arr_en = 1'b0;
        ready  = 1'b0;
        unique case (state_q)
            ST_SHUTDOWN: ;
            ST_STANDBY: begin
                ref_en = 1'b1;
                amp_en = 1'b1;
            end
            ST_SETTLE: begin
                ref_en = 1'b1;
                amp_en = 1'b1;
                arr_en = 1'b1;
            end
            ST_ACTIVE: begin
                ref_en = 1'b1;
                amp_en = 1'b1;
                arr_en = 1'b1;
                ready  = 1'b1;
            end
            default: ;
        endcase
        out_gnd = OUT_GND  && !ready;
        out_hiz = !OUT_GND && !ready;
    end

    assign hold_wr = code_ld && (state_q == ST_ACTIVE);

    logic [CODE_W-1:0] code_in [NCH];
    logic [CODE_W-1:0] code_q  [NCH];
    assign code_in[0] = code_a;
    assign code_in[1] = code_b;

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            dac_pwr_hold #(.W(CODE_W)) u_hold (
                .clk  (clk),
                .rst_n(rst_n),
                .wr   (hold_wr),
                .d    (code_in[c]),
                .q    (code_q[c])
            );
        end
    endgenerate

    assign dout_a = code_q[0];
    assign dout_b = code_q[1];
endmodule

// File: rtl/dac_pwr_seq_chk.sv
module dac_pwr_seq_chk #(
    parameter int unsigned SETTLE_CYC = 16,
    parameter bit          OUT_GND    = 1'b0,
    parameter int          CODE_W     = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pd_s,
    input logic              en_s,
    input logic              ref_en,
    input logic              amp_en,
    input logic              arr_en,
    input logic              out_hiz,
    input logic              out_gnd,
    input logic              ready,
    input logic [CODE_W-1:0] dout_a,
    input logic [CODE_W-1:0] dout_b
);
    localparam int unsigned RW = $clog2(SETTLE_CYC + 2);
    logic [RW-1:0] run_cnt;

    // consecutive cycles of array on with outputs invalid, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 run_cnt <= '0;
        else if (!(arr_en && !ready)) run_cnt <= '0;
        else if (run_cnt != RW'(SETTLE_CYC + 1)) run_cnt <= run_cnt + RW'(1);
    end

    p_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd_s && !en_s) |=> (ref_en && amp_en && !arr_en && !ready));

    p_active_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (ref_en && amp_en && arr_en));

    p_shutdown_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pd_s |=> (!ref_en && !amp_en && !arr_en && !ready));

    p_park_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({out_hiz, out_gnd}) == (ready ? 0 : 1)) &&
        (out_gnd == (OUT_GND && !ready)));

    p_settle_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (run_cnt == RW'(SETTLE_CYC)));

    p_codes_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> ($stable(dout_a) && $stable(dout_b)));

    p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_s && !ready) |=> !ready);
endmodule

bind dac_pwr_seq dac_pwr_seq_chk #(
    .SETTLE_CYC(SETTLE_CYC),
    .OUT_GND   (OUT_GND),
    .CODE_W    (CODE_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pd_s   (pd_s),
    .en_s   (en_s),
    .ref_en (ref_en),
    .amp_en (amp_en),
    .arr_en (arr_en),
    .out_hiz(out_hiz),
    .out_gnd(out_gnd),
    .ready  (ready),
    .dout_a (dout_a),
    .dout_b (dout_b)
);

// File: tb/dac_pwr_seq_tb_top.sv
module dac_pwr_seq_tb_top;
    localparam longint unsigned CLK_HZ = 200_000;
    localparam int unsigned SET_US = 50;
    localparam int N   = 10;   // 200 kHz * 50 us
    localparam bit  GND = 1'b1;
    localparam int  W   = 10;

    localparam int M_SHUT = 0, M_STBY = 1, M_SETL = 2, M_ACT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_req = 1'b1, en_req = 1'b0, code_ld = 1'b0;
    logic [W-1:0] code_a = '0, code_b = '0;
    logic ref_en, amp_en, arr_en, out_hiz, out_gnd, ready;
    logic [W-1:0] dout_a, dout_b;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    dac_pwr_seq #(.CLK_HZ(CLK_HZ), .SETTLE_US(SET_US), .OUT_GND(GND), .CODE_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .en_req(en_req),
        .code_a(code_a), .code_b(code_b), .code_ld(code_ld),
        .ref_en(ref_en), .amp_en(amp_en), .arr_en(arr_en),
        .out_hiz(out_hiz), .out_gnd(out_gnd), .ready(ready),
        .dout_a(dout_a), .dout_b(dout_b)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    // ---- requirement-level model ----
    int m_st = M_SHUT, m_cnt = 0;
    logic m_p1 = 1'b1, m_p2 = 1'b1, m_e1 = 1'b0, m_e2 = 1'b0;
    logic [W-1:0] m_a = '0, m_b = '0;

    function automatic int next_st(int st, logic p, logic e, int cnt);
        if (p) return M_SHUT;
        if (!e) return M_STBY;
        if (st == M_SETL) return (cnt == N - 1) ? M_ACT : M_SETL;
        if (st == M_ACT) return M_ACT;
        return M_SETL;
    endfunction

    function automatic string st_tag(int st);
        case (st)
            M_SHUT:  return "R3";
            M_STBY:  return "R1";
            M_SETL:  return "R5";
            default: return "R2";
        endcase
    endfunction

    always @(posedge clk) begin
        int nx;
        if (!rst_n) begin
            m_st = M_SHUT; m_cnt = 0;
            m_p1 = 1'b1; m_p2 = 1'b1; m_e1 = 1'b0; m_e2 = 1'b0;
            m_a = '0; m_b = '0;
        end else begin
            if (m_st == M_ACT && code_ld) begin m_a = code_a; m_b = code_b; end
            nx = next_st(m_st, m_p2, m_e2, m_cnt);
            m_cnt = (m_st == M_SETL) ? m_cnt + 1 : 0;
            m_st = nx;
            m_p2 = m_p1; m_p1 = pd_req;
            m_e2 = m_e1; m_e1 = en_req;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            chk(st_tag(m_st), "ref_en", ref_en, m_st != M_SHUT);
            chk(st_tag(m_st), "amp_en", amp_en, m_st != M_SHUT);
            chk(st_tag(m_st), "arr_en", arr_en, m_st == M_SETL || m_st == M_ACT);
            chk(st_tag(m_st), "ready",  ready,  m_st == M_ACT);
            chk("R4", "park", {out_hiz, out_gnd},
                (m_st == M_ACT) ? 2'b00 : (GND ? 2'b01 : 2'b10));
            chk("R6", "dout_a", dout_a, m_a);
            chk("R6", "dout_b", dout_b, m_b);
        end
    end

    task automatic finish_run;
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // count settle cycles until ready rises
    task automatic measure_settle(input string tag);
        int c = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (arr_en && !ready) c++;
            if (ready) break;
        end
        chk(tag, "settle cycles", c, N);
    endtask

    initial begin
        void'($urandom(32'd1234));
        // R9: reset values
        cyc(3);
        chk("R9", "ref_en in reset", ref_en, 0);
        chk("R9", "arr_en in reset", arr_en, 0);
        chk("R9", "ready in reset", ready, 0);
        chk("R9", "gnd park in reset", out_gnd, 1);
        chk("R9", "dout_a in reset", dout_a, 0);
        rst_n = 1'b1;
        cyc(4);

        // R8: pd drop reaches ref_en on third edge
        pd_req = 1'b0; en_req = 1'b0;
        cyc(2);
        chk("R8", "ref_en after 2 edges", ref_en, 0);
        cyc(1);
        chk("R8", "ref_en after 3 edges", ref_en, 1);
        chk("R1", "standby arr_en", arr_en, 0);
        cyc(3);

        // R5: wake from standby
        en_req = 1'b1;
        measure_settle("R5");
        chk("R2", "active ready", ready, 1);

        // R6: load in active, ignore while asleep, restore on wake
        code_a = 10'h2A5; code_b = 10'h15A; code_ld = 1'b1;
        cyc(1);
        code_ld = 1'b0;
        chk("R6", "loaded a", dout_a, 10'h2A5);
        chk("R6", "loaded b", dout_b, 10'h15A);
        en_req = 1'b0;
        cyc(5);
        code_a = 10'h0FF; code_b = 10'h300; code_ld = 1'b1;
        cyc(3);
        chk("R6", "standby ignores load a", dout_a, 10'h2A5);
        pd_req = 1'b1; en_req = 1'b1;
        cyc(5);
        chk("R3", "shutdown with enable high", {ref_en, amp_en, arr_en}, 0);
        chk("R6", "shutdown ignores load b", dout_b, 10'h15A);
        code_ld = 1'b0;
        pd_req = 1'b0;
        measure_settle("R5");
        chk("R6", "restored a", dout_a, 10'h2A5);
        chk("R6", "restored b", dout_b, 10'h15A);

        // R7: abort settle and restart
        en_req = 1'b0;
        cyc(6);
        en_req = 1'b1;
        cyc(7);
        en_req = 1'b0;
        cyc(4);
        chk("R7", "aborted to standby", {arr_en, ready, ref_en}, 3'b001);
        en_req = 1'b1;
        measure_settle("R7");
        pd_req = 1'b1;
        cyc(7);
        pd_req = 1'b0;
        measure_settle("R7");

        // random phase
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if ($urandom_range(15) == 0) pd_req = ($urandom_range(3) == 0);
            if ($urandom_range(15) == 0) en_req = ($urandom_range(3) != 0);
            code_ld = $urandom_range(1);
            code_a  = W'($urandom);
            code_b  = W'($urandom);
        end
        code_ld = 1'b0;
        cyc(2);
        finish_run();
    end
endmodule